// File: doc/BRIEF.md
# Two-Stage Watchdog Timer on an APB Slave Port

This block is a 32-bit down-counting watchdog that sits on an APB bus. It counts only on cycles where a separate clock-enable tick input is high. When the count runs out for the first time, the block raises an interrupt flag and reloads itself from the load register. If software does not clear that flag before the count runs out a second time, the block latches a sticky reset request and stops counting. Software sees the load value, the live count, the raw and gated interrupt status, and a control register that gates each of the two outputs.

A lock register guards every other register. Writing the key 0x1ACCE551 to it opens the block, and writing any other value closes it. An integration-test mode lets software drive both outputs directly from a test register. Twelve read-only identification registers return one byte each from a parameter.

A parameter selects a restricted variant. In that variant the control register can no longer be changed once the interrupt enable is set, and the integration-test registers do not exist.

Top module: `apb_wdt`

## Requirements
- R1: After reset the load register and the count both read 0xFFFFFFFF, and the counter is running. Control, raw status, lock and test control read 0, and both outputs are low.
- R2: Control (offset 0x008) keeps only bit 0 (interrupt enable) and bit 1 (reset enable), and the other written bits read back as 0.
- R3: A write to load (offset 0x000) sets both the reload value and the count (offset 0x004) to the written data and starts the counter.
- R4: The count drops by one only on a cycle where `tickEn` is high, and holds on every other cycle.
- R5: The count expires on a tick with count ≤ 1.
  - If the raw flag (offset 0x010, bit 0) is clear, expiry sets the flag and reloads the count.
  - If the flag is already set, expiry sets a sticky reset status, forces the count to 0 and stops counting.
- R6: `wdogInt` is the raw flag AND control bit 0, and masked status (offset 0x014) returns the same value. `wdogRes` is the reset status AND control bit 1.
- R7: Any write to interrupt clear (offset 0x00C) clears the raw flag and reloads the count from the load value.
- R8: Writing 0x1ACCE551 to lock (offset 0xC00) unlocks the block, and any other value locks it. Lock reads 1 when locked. While locked, every write except a write to lock is ignored.
- R9: Writes to count, raw status and masked status have no effect. Interrupt clear and test output (offset 0xF04) read as 0.
- R10: Offsets 0xFD0 to 0xFFC are read-only. Each returns byte (offset-0xFD0)/4 of `ID_BYTES`, counting from the least significant byte.
- R11: While test control (offset 0xF00) bit 0 is set, `wdogInt` follows test output bit 1 and `wdogRes` follows test output bit 0.
- R12: With `FREEZE_ON_INTEN` set:
  - control writes are ignored while control bit 0 is 1;
  - test control reads 0 and has no effect on the outputs.
- R13: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always no error |
| tickEn | input | 1 | Watchdog count enable |
| wdogInt | output | 1 | Interrupt request |
| wdogRes | output | 1 | Reset request |

## Verification
The bench drives the counter through both expiry stages with small load values. A design that reloaded on the wrong stage, or kept counting after the reset stage, would show a nonzero count or a low reset request. It checks that an interrupt clear reloads the count, so a design that cleared only the flag would leave the partly spent count visible. It checks that a locked block ignores writes to load, control and clear, and that writes to read-only registers cannot change the count, the flag or the ID bytes. It also checks the test-mode output override and the control freeze of the variant: a variant that still accepted control writes, or kept live test registers, would read back the wrong control or test value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_TCTRL = 12'hF00;
  localparam logic [ADDR_W-1:0] OFS_TOUT  = 12'hF04;
  localparam logic [ADDR_W-1:0] OFS_ID_LO = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_ID_HI = 12'hFFC;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam int ID_COUNT = 12;

  typedef struct packed {
    logic              loadWr;
    logic              clrWr;
    logic [DATA_W-1:0] wdata;
  } cntStrobe_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] loadVal,
  output logic             intFlag,
  output logic             resetStatus
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  logic expire;

  assign expire = tickEn && running && (countVal <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal     <= '1;
      countVal    <= '1;
      running     <= 1'b1;
      intFlag     <= 1'b0;
      resetStatus <= 1'b0;
    end else if (strobe.loadWr) begin
      loadVal  <= strobe.wdata[CNT_W-1:0];
      countVal <= strobe.wdata[CNT_W-1:0];
      running  <= 1'b1;
    end else if (strobe.clrWr) begin
      intFlag  <= 1'b0;
      countVal <= loadVal;
    end else if (expire) begin
      if (!intFlag) begin
        intFlag  <= 1'b1;
        countVal <= loadVal;
      end else begin
        resetStatus <= 1'b1;
        running     <= 1'b0;
        countVal    <= '0;
      end
    end else if (tickEn && running) begin
      countVal <= countVal - ONE;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          CNT_W           = DATA_W,
  parameter bit          FREEZE_ON_INTEN = 1'b0,
  parameter logic [95:0] ID_BYTES        = 96'h5A3CE107_00429B16_00000002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              intFlag,
  input  logic              resetStatus,
  output cntStrobe_t        strobe,
  output logic [DATA_W-1:0] prdata,
  output logic              wdogInt,
  output logic              wdogRes,
  output logic              lockOn
);
  logic       wrEn;
  logic       wrOpen;
  logic [1:0] ctrlQ;
  logic       testEn;
  logic [1:0] testOut;
  logic       maskedInt;
  logic       maskedRes;
  logic       isId;
  logic [ADDR_W-1:0] idOfs;
  logic [7:0] idByte;

  assign wrEn   = psel && penable && pwrite;
  assign wrOpen = wrEn && (!lockOn || paddr == OFS_LOCK);

  assign strobe.loadWr = wrOpen && paddr == OFS_LOAD;
  assign strobe.clrWr  = wrOpen && paddr == OFS_CLR;
  assign strobe.wdata  = pwdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockOn <= 1'b0;
    end else if (wrEn && paddr == OFS_LOCK) begin
      lockOn <= (pwdata != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= 2'b00;
    end else if (wrOpen && paddr == OFS_CTRL && !(FREEZE_ON_INTEN && ctrlQ[0])) begin
      ctrlQ <= pwdata[1:0];
    end
  end

  generate
    if (FREEZE_ON_INTEN) begin : g_noTest
      assign testEn  = 1'b0;
      assign testOut = 2'b00;
    end else begin : g_test
      logic       testEnQ;
      logic [1:0] testOutQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          testEnQ  <= 1'b0;
          testOutQ <= 2'b00;
        end else begin
          if (wrOpen && paddr == OFS_TCTRL) testEnQ  <= pwdata[0];
          if (wrOpen && paddr == OFS_TOUT)  testOutQ <= pwdata[1:0];
        end
      end
      assign testEn  = testEnQ;
      assign testOut = testOutQ;
    end
  endgenerate

  assign maskedInt = intFlag && ctrlQ[0];
  assign maskedRes = resetStatus && ctrlQ[1];
  assign wdogInt   = testEn ? testOut[1] : maskedInt;
  assign wdogRes   = testEn ? testOut[0] : maskedRes;

  assign isId   = (paddr >= OFS_ID_LO) && (paddr <= OFS_ID_HI) && (paddr[1:0] == 2'b00);
  assign idOfs  = (paddr - OFS_ID_LO) >> 2;
  assign idByte = isId ? ID_BYTES[idOfs[3:0]*8 +: 8] : 8'h00;

  always_comb begin
    prdata = '0;
    if (isId) begin
      prdata = {24'h0, idByte};
    end else begin
      case (paddr)
        OFS_LOAD:  prdata = DATA_W'(loadVal);
        OFS_VALUE: prdata = DATA_W'(countVal);
        OFS_CTRL:  prdata = {30'h0, ctrlQ};
        OFS_RAW:   prdata = {31'h0, intFlag};
        OFS_MASK:  prdata = {31'h0, maskedInt};
        OFS_LOCK:  prdata = {31'h0, lockOn};
        OFS_TCTRL: prdata = {31'h0, testEn};
        default:   prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/apb_wdt.sv
module apb_wdt
  import wdt_pkg::*;
#(
  parameter bit          FREEZE_ON_INTEN = 1'b0,
  parameter logic [95:0] ID_BYTES        = 96'h5A3CE107_00429B16_00000002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tickEn,
  output logic              wdogInt,
  output logic              wdogRes
);
  localparam int CNT_W = DATA_W;

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] loadVal;
  logic             intFlag;
  logic             resetStatus;
  logic             lockOn;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt_regs #(
    .CNT_W(CNT_W), .FREEZE_ON_INTEN(FREEZE_ON_INTEN), .ID_BYTES(ID_BYTES)
  ) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .countVal(countVal), .loadVal(loadVal),
    .intFlag(intFlag), .resetStatus(resetStatus), .strobe(strobe),
    .prdata(prdata), .wdogInt(wdogInt), .wdogRes(wdogRes), .lockOn(lockOn)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .countVal(countVal), .loadVal(loadVal), .intFlag(intFlag),
    .resetStatus(resetStatus)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] loadVal,
  input logic              intFlag,
  input logic              resetStatus,
  input logic              lockOn
);
  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  a_r13_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    pready && !pslverr);

  a_r3_load_sets_count: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && !lockOn && paddr == OFS_LOAD) |=>
      (countVal == $past(pwdata) && loadVal == $past(pwdata)));

  a_r7_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && !lockOn && paddr == OFS_CLR) |=> !intFlag);

  a_r8_locked_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && lockOn && paddr == OFS_LOAD) |=> $stable(loadVal));

  a_r5_reset_sticky: assert property (@(posedge clk) disable iff (!rstN)
    resetStatus |=> resetStatus);

  a_r5_reset_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetStatus) |-> countVal == '0);
endmodule

bind apb_wdt wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .countVal(countVal), .loadVal(loadVal), .intFlag(intFlag),
  .resetStatus(resetStatus), .lockOn(lockOn)
);

// File: tb/apb_wdt_tb.sv
module apb_wdt_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] A_LOAD = 12'h000, A_VALUE = 12'h004, A_CTRL = 12'h008,
    A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014, A_LOCK = 12'hC00,
    A_TCTRL = 12'hF00, A_TOUT = 12'hF04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tgtVar = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic tickEn = 1'b0;
  logic [31:0] prdMain, prdVar;
  logic readyMain, errMain, readyVar, errVar;
  logic intMain, resMain, intVar, resVar;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_wdt u_dut (
    .clk(clk), .rstN(rstN), .psel(psel && !tgtVar), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdMain),
    .pready(readyMain), .pslverr(errMain), .tickEn(tickEn),
    .wdogInt(intMain), .wdogRes(resMain)
  );

  apb_wdt #(.FREEZE_ON_INTEN(1'b1)) u_var (
    .clk(clk), .rstN(rstN), .psel(psel && tgtVar), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdVar),
    .pready(readyVar), .pslverr(errVar), .tickEn(1'b0),
    .wdogInt(intVar), .wdogRes(resVar)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic apbWrite(input logic v, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    tgtVar = v; psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic v, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    tgtVar = v; psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = v ? prdVar : prdMain;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apbRead(1'b0, a, d);
    check(tag, d, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tResetState();
    readCheck("R1 load", A_LOAD, 32'hFFFF_FFFF);
    readCheck("R1 count", A_VALUE, 32'hFFFF_FFFF);
    readCheck("R1 ctrl", A_CTRL, 0);
    readCheck("R1 raw", A_RAW, 0);
    readCheck("R1 lock", A_LOCK, 0);
    readCheck("R1 tctrl", A_TCTRL, 0);
    check("R1 int", {31'h0, intMain}, 0);
    check("R1 res", {31'h0, resMain}, 0);
    check("R13 ready/err", {30'h0, readyMain, errMain}, 32'h2);
  endtask

  task automatic tCtrlMask();
    apbWrite(0, A_CTRL, 32'hFFFF_FFFF);
    readCheck("R2 ctrl masked", A_CTRL, 3);
    apbWrite(0, A_CTRL, 32'hFFFF_FFFC);
    readCheck("R2 ctrl cleared", A_CTRL, 0);
  endtask

  task automatic tLoadCount();
    apbWrite(0, A_LOAD, 3);
    readCheck("R3 count", A_VALUE, 3);
    readCheck("R3 load", A_LOAD, 3);
    ticks(2);
    readCheck("R4 count after 2 ticks", A_VALUE, 1);
    repeat (6) @(negedge clk);
    readCheck("R4 hold without tick", A_VALUE, 1);
  endtask

  task automatic tFirstExpiry();
    apbWrite(0, A_CTRL, 1);
    ticks(1);
    readCheck("R5 first expiry flag", A_RAW, 1);
    readCheck("R5 reload", A_VALUE, 3);
    readCheck("R6 masked", A_MASK, 1);
    check("R6 int out", {31'h0, intMain}, 1);
  endtask

  task automatic tClear();
    ticks(1);
    readCheck("R7 pre count", A_VALUE, 2);
    apbWrite(0, A_CLR, 32'hDEAD);
    readCheck("R7 flag cleared", A_RAW, 0);
    readCheck("R7 count reloaded", A_VALUE, 3);
    check("R7 int low", {31'h0, intMain}, 0);
  endtask

  task automatic tSecondExpiry();
    apbWrite(0, A_CTRL, 3);
    ticks(3);
    readCheck("R5 flag again", A_RAW, 1);
    check("R5 no reset yet", {31'h0, resMain}, 0);
    ticks(3);
    check("R5 reset out", {31'h0, resMain}, 1);
    readCheck("R5 count zero", A_VALUE, 0);
    ticks(4);
    readCheck("R5 stopped", A_VALUE, 0);
    apbWrite(0, A_CTRL, 1);
    check("R6 reset gated", {31'h0, resMain}, 0);
  endtask

  task automatic tGating();
    apbWrite(0, A_LOAD, 1);
    ticks(1);
    readCheck("R6 raw set", A_RAW, 1);
    readCheck("R6 masked off", A_MASK, 0);
    check("R6 int gated", {31'h0, intMain}, 0);
  endtask

  task automatic tLock();
    apbWrite(0, A_LOCK, 32'h0000_1234);
    readCheck("R8 locked", A_LOCK, 1);
    apbWrite(0, A_LOAD, 9);
    readCheck("R8 load ignored", A_LOAD, 1);
    apbWrite(0, A_CTRL, 3);
    readCheck("R8 ctrl ignored", A_CTRL, 0);
    apbWrite(0, A_CLR, 0);
    readCheck("R8 clear ignored", A_RAW, 1);
    apbWrite(0, A_LOCK, 32'h1ACC_E551);
    readCheck("R8 unlocked", A_LOCK, 0);
    apbWrite(0, A_LOAD, 9);
    readCheck("R8 load works", A_LOAD, 9);
  endtask

  task automatic tReadOnly();
    apbWrite(0, A_RAW, 0);
    readCheck("R9 raw ro", A_RAW, 1);
    apbWrite(0, A_MASK, 1);
    apbWrite(0, A_VALUE, 32'h55);
    readCheck("R9 count ro", A_VALUE, 9);
    readCheck("R9 clear reads 0", A_CLR, 0);
    apbWrite(0, A_TOUT, 3);
    readCheck("R9 tout reads 0", A_TOUT, 0);
    check("R9 no override off", {30'h0, intMain, resMain}, 0);
    readCheck("R10 id 0", 12'hFD0, 32'h02);
    readCheck("R10 id 4", 12'hFE0, 32'h16);
    readCheck("R10 id 11", 12'hFFC, 32'h5A);
    apbWrite(0, 12'hFE0, 32'hFF);
    readCheck("R10 id ro", 12'hFE0, 32'h16);
  endtask

  task automatic tTestMode();
    apbWrite(0, A_TOUT, 2);
    apbWrite(0, A_TCTRL, 1);
    check("R11 int forced", {30'h0, intMain, resMain}, 32'h2);
    readCheck("R11 tctrl", A_TCTRL, 1);
    apbWrite(0, A_TOUT, 1);
    check("R11 res forced", {30'h0, intMain, resMain}, 32'h1);
    apbWrite(0, A_TCTRL, 0);
    check("R11 normal again", {30'h0, intMain, resMain}, 0);
  endtask

  task automatic tVariant();
    logic [31:0] d;
    apbWrite(1, A_CTRL, 2);
    apbRead(1, A_CTRL, d);  check("R12 ctrl open", d, 2);
    apbWrite(1, A_CTRL, 1);
    apbWrite(1, A_CTRL, 2);
    apbRead(1, A_CTRL, d);  check("R12 ctrl frozen", d, 1);
    apbWrite(1, A_TOUT, 3);
    apbWrite(1, A_TCTRL, 1);
    apbRead(1, A_TCTRL, d); check("R12 tctrl absent", d, 0);
    check("R12 no override", {30'h0, intVar, resVar}, 0);
    check("R13 variant ready/err", {30'h0, readyVar, errVar}, 32'h2);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();
    tResetState();
    tCtrlMask();
    tLoadCount();
    tFirstExpiry();
    tClear();
    tSecondExpiry();
    doReset();
    tGating();
    tLock();
    tReadOnly();
    tTestMode();
    tVariant();
    finishRun();
  end
endmodule